// File: doc/BRIEF.md
# Flash Program and Erase Command Driver

This block sits on the host side of a byte-wide parallel flash device. It takes one request at a time: program a single byte, erase the whole chip, or erase one block. It then produces the unlock and command write cycles that the device expects, and polls the device status until the operation ends. When the operation is over, it pulses `done` and reports failure on `error`.

Completion is found by comparing status bit 6 across consecutive reads. A device that has stopped toggling has finished. If status bit 5 is high while bit 6 still toggles, the block makes one more read as a confirmation. If that read also shows bit 6 moving, the operation has failed.

On any failure, including a poll budget that runs out, the driver writes the return-to-read command. After an erase it also waits out a recovery interval before it reports the result, so a new request can never reach the device too early. Every bus write is framed by one setup cycle and one hold cycle around a single-cycle strobe.

Top module: `flash_cmd_driver`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, `busy`, `done`, `error`, `fl_wr` and `fl_rd` are all low.
- R2: Opcode 0 (byte program) writes, in order, AAh to 5555h, 55h to 2AAAh, A0h to 5555h, and then `req_data` to `req_addr`.
- R3: Opcode 1 (chip erase) writes, in order, AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, and then 10h@5555h.
- R4: Opcode 2 (block erase) writes the same first five cycles as R3, and then 30h to `req_addr`.
- R5: For every write, `fl_addr` and `fl_dout` hold their value in the cycle before the one-cycle `fl_wr` pulse and in the cycle after it. `fl_wr` and `fl_rd` are never high together.
- R6: After the last command write, the driver reads status at `req_addr`, one cycle per read. When two consecutive reads show the same bit 6, `done` rises in the cycle right after that read, with `error` low.
- R7: A read whose bit 6 differs from the previous read, and whose bit 5 is 1, triggers one more read. If bit 6 differs again on that read, the result is an error. If it matches, the result is success.
- R8: If `MAX_POLLS` status reads go by without a verdict, the result is an error.
- R9: On any error, the driver writes F0h to 5555h before it reports `done` with `error` high. This write does not happen on success.
- R10: After the error write's strobe, `done` follows by exactly 2 cycles for a program, and by exactly `RST_WAIT_CYC`+2 cycles for an erase.
- R11: A request is accepted only when the block is idle and `req_op` is not 3. Requests made while busy, and opcode 3, do not change the bus activity.
- R12: `done` is a one-cycle pulse, and `busy` is low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_op | input | 2 | 0 program, 1 chip erase, 2 block erase, 3 no-op |
| req_addr | input | ADDR_W | Target byte or block address |
| req_data | input | 8 | Byte to program |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| error | output | 1 | Failure, valid with `done` |
| fl_addr | output | ADDR_W | Flash address bus |
| fl_dout | output | 8 | Flash write data |
| fl_din | input | 8 | Flash read data, sampled on the clock edge that ends a read |
| fl_wr | output | 1 | Write strobe, active high |
| fl_rd | output | 1 | Read strobe, active high |

## Verification
Each bus write takes 3 cycles, and there is one idle cycle before the next access. Each status read lasts one cycle. A successful `done` is due exactly one cycle after the last read strobe. An error `done` is due 2 cycles after the reset-write strobe, or `RST_WAIT_CYC`+2 cycles after it for an erase. The bench records the cycle of every strobe at falling edges and compares those recorded cycles with the exact offsets. The expected number of reads and the verdict are computed from the toggle, flip-count and bit-5 settings of a behavioural device model.

// File: rtl/flash_drv_pkg.sv
package flash_drv_pkg;
   typedef enum logic [1:0] {OP_PROG = 2'd0, OP_CHIP = 2'd1, OP_BLOCK = 2'd2, OP_NONE = 2'd3} fop_e;
   typedef enum logic [1:0] {V_CONT, V_OK, V_FAIL} verdict_e;
   typedef enum logic [2:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD, PH_READ} phase_e;

   localparam logic [15:0] UNL_ADDR_A = 16'h5555;
   localparam logic [15:0] UNL_ADDR_B = 16'h2AAA;
   localparam logic [7:0]  CODE_KEY1  = 8'hAA;
   localparam logic [7:0]  CODE_KEY2  = 8'h55;
   localparam logic [7:0]  CODE_PROG  = 8'hA0;
   localparam logic [7:0]  CODE_ERSU  = 8'h80;
   localparam logic [7:0]  CODE_CHIP  = 8'h10;
   localparam logic [7:0]  CODE_BLK   = 8'h30;
   localparam logic [7:0]  CODE_RARR  = 8'hF0;
   localparam int          TOG_BIT    = 6;
   localparam int          FAIL_BIT   = 5;
endpackage

// File: rtl/flash_seq_table.sv
module flash_seq_table
   import flash_drv_pkg::*;
#(
   parameter int ADDR_W = 19
) (
   input  fop_e              op,
   input  logic [2:0]        step,
   input  logic [ADDR_W-1:0] tgt_addr,
   input  logic [7:0]        tgt_data,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [7:0]        wr_data,
   output logic              last
);
   localparam logic [ADDR_W-1:0] ADR_A = ADDR_W'(UNL_ADDR_A);
   localparam logic [ADDR_W-1:0] ADR_B = ADDR_W'(UNL_ADDR_B);
   localparam logic [2:0] PROG_LAST  = 3'd3;
   localparam logic [2:0] ERASE_LAST = 3'd5;

   always_comb begin
      wr_addr = ADR_A;
      wr_data = CODE_KEY1;
      case (step)
         3'd1, 3'd4: begin
            wr_addr = ADR_B;
            wr_data = CODE_KEY2;
         end
         3'd2: wr_data = (op == OP_PROG) ? CODE_PROG : CODE_ERSU;
         3'd3: if (op == OP_PROG) begin
            wr_addr = tgt_addr;
            wr_data = tgt_data;
         end
         3'd5: if (op == OP_BLOCK) begin
            wr_addr = tgt_addr;
            wr_data = CODE_BLK;
         end else begin
            wr_data = CODE_CHIP;
         end
         default: ;
      endcase
      last = (op == OP_PROG) ? (step == PROG_LAST) : (step == ERASE_LAST);
   end
endmodule

// File: rtl/flash_bus_cycle.sv
module flash_bus_cycle
   import flash_drv_pkg::*;
#(
   parameter int ADDR_W = 19
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              is_read,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        data,
   output logic              idle,
   output logic              ack,
   output logic [ADDR_W-1:0] fl_addr,
   output logic [7:0]        fl_dout,
   output logic              fl_wr,
   output logic              fl_rd
);
   phase_e            phase;
   logic [ADDR_W-1:0] a_r;
   logic [7:0]        d_r;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         a_r   <= '0;
         d_r   <= '0;
      end else begin
         case (phase)
            PH_IDLE: if (start) begin
               a_r   <= addr;
               d_r   <= data;
               phase <= is_read ? PH_READ : PH_SETUP;
            end
            PH_SETUP:  phase <= PH_STROBE;
            PH_STROBE: phase <= PH_HOLD;
            default:   phase <= PH_IDLE;
         endcase
      end
   end

   assign idle    = (phase == PH_IDLE);
   assign ack     = (phase == PH_HOLD) || (phase == PH_READ);
   assign fl_addr = a_r;
   assign fl_dout = d_r;
   assign fl_wr   = (phase == PH_STROBE);
   assign fl_rd   = (phase == PH_READ);

   // R5
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(fl_wr && fl_rd));
   // R5
   wr_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fl_wr |-> ($stable(fl_addr) && $stable(fl_dout)));
   // R5
   wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fl_wr) |-> ($stable(fl_addr) && $stable(fl_dout)));
endmodule

// File: rtl/flash_toggle_judge.sv
module flash_toggle_judge
   import flash_drv_pkg::*;
(
   input  logic     first,
   input  logic     prev_tog,
   input  logic     cur_tog,
   input  logic     cur_fail,
   input  logic     recheck,
   output verdict_e verdict,
   output logic     set_recheck
);
   always_comb begin
      verdict     = V_CONT;
      set_recheck = 1'b0;
      if (!first) begin
         if (cur_tog == prev_tog)  verdict = V_OK;
         else if (recheck)         verdict = V_FAIL;
         else                      set_recheck = cur_fail;
      end
   end
endmodule

// File: rtl/flash_cmd_driver.sv
module flash_cmd_driver
   import flash_drv_pkg::*;
#(
   parameter int ADDR_W       = 19,
   parameter int MAX_POLLS    = 1024,
   parameter int RST_WAIT_CYC = 625
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [7:0]        req_data,
   output logic              busy,
   output logic              done,
   output logic              error,
   output logic [ADDR_W-1:0] fl_addr,
   output logic [7:0]        fl_dout,
   input  logic [7:0]        fl_din,
   output logic              fl_wr,
   output logic              fl_rd
);
   localparam int PW     = $clog2(MAX_POLLS + 1);
   localparam int WAIT_W = (RST_WAIT_CYC > 1) ? $clog2(RST_WAIT_CYC) : 1;
   localparam logic [ADDR_W-1:0] ADR_A = ADDR_W'(UNL_ADDR_A);

   generate
      if (ADDR_W < 16 || MAX_POLLS < 2 || RST_WAIT_CYC < 0) begin : g_bad_cfg
         $error("flash_cmd_driver: parameter out of range");
      end
   endgenerate

   typedef enum logic [2:0] {S_IDLE, S_CMD, S_POLL, S_RST, S_WAIT, S_FIN} st_e;
   st_e               state;
   fop_e              op_q;
   logic [ADDR_W-1:0] addr_q;
   logic [7:0]        data_q;
   logic [2:0]        step_q;
   logic              first_q, prev_q, recheck_q, err_q;
   logic [PW-1:0]     polls_q, polls_n;

   logic [ADDR_W-1:0] seq_addr, l_addr;
   logic [7:0]        seq_data, l_data;
   logic              seq_last, launch, bus_idle, bus_ack, wait_done, set_rc, timeout;
   verdict_e          verdict;
   wire               unused_din = ^{fl_din[7], fl_din[4:0]};

   flash_seq_table #(.ADDR_W(ADDR_W)) u_table (
      .op(op_q), .step(step_q), .tgt_addr(addr_q), .tgt_data(data_q),
      .wr_addr(seq_addr), .wr_data(seq_data), .last(seq_last));

   always_comb begin
      launch = bus_idle && (state == S_CMD || state == S_POLL || state == S_RST);
      l_addr = (state == S_CMD) ? seq_addr : (state == S_RST) ? ADR_A : addr_q;
      l_data = (state == S_CMD) ? seq_data : CODE_RARR;
   end

   flash_bus_cycle #(.ADDR_W(ADDR_W)) u_bus (
      .clk(clk), .rst_n(rst_n), .start(launch), .is_read(state == S_POLL),
      .addr(l_addr), .data(l_data), .idle(bus_idle), .ack(bus_ack),
      .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_wr(fl_wr), .fl_rd(fl_rd));

   flash_toggle_judge u_judge (
      .first(first_q), .prev_tog(prev_q), .cur_tog(fl_din[TOG_BIT]),
      .cur_fail(fl_din[FAIL_BIT]), .recheck(recheck_q),
      .verdict(verdict), .set_recheck(set_rc));

   assign polls_n = polls_q + 1'b1;
   assign timeout = (polls_n == PW'(MAX_POLLS));

   generate
      if (RST_WAIT_CYC > 0) begin : g_wait
         logic [WAIT_W-1:0] wcnt;
         always_ff @(posedge clk) begin
            if (!rst_n || state != S_WAIT) wcnt <= '0;
            else                           wcnt <= wcnt + 1'b1;
         end
         assign wait_done = (wcnt == WAIT_W'(RST_WAIT_CYC - 1));
      end else begin : g_nowait
         assign wait_done = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         op_q      <= OP_PROG;
         addr_q    <= '0;
         data_q    <= '0;
         step_q    <= '0;
         first_q   <= 1'b1;
         prev_q    <= 1'b0;
         recheck_q <= 1'b0;
         err_q     <= 1'b0;
         polls_q   <= '0;
      end else begin
         case (state)
            S_IDLE: if (req_valid && fop_e'(req_op) != OP_NONE) begin
               op_q   <= fop_e'(req_op);
               addr_q <= req_addr;
               data_q <= req_data;
               step_q <= '0;
               err_q  <= 1'b0;
               state  <= S_CMD;
            end
            S_CMD: if (bus_ack) begin
               if (seq_last) begin
                  state     <= S_POLL;
                  first_q   <= 1'b1;
                  recheck_q <= 1'b0;
                  polls_q   <= '0;
               end else begin
                  step_q <= step_q + 1'b1;
               end
            end
            S_POLL: if (bus_ack) begin
               polls_q <= polls_n;
               prev_q  <= fl_din[TOG_BIT];
               first_q <= 1'b0;
               if (verdict == V_OK) begin
                  state <= S_FIN;
               end else if (verdict == V_FAIL || timeout) begin
                  err_q <= 1'b1;
                  state <= S_RST;
               end else begin
                  recheck_q <= recheck_q | set_rc;
               end
            end
            S_RST: if (bus_ack) begin
               state <= (op_q != OP_PROG && RST_WAIT_CYC > 0) ? S_WAIT : S_FIN;
            end
            S_WAIT: if (wait_done) state <= S_FIN;
            default: state <= S_IDLE;
         endcase
      end
   end

   assign busy  = (state != S_IDLE);
   assign done  = (state == S_FIN);
   assign error = done && err_q;

   // R12
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> (!done && !busy));
   // R6
   ok_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n) (done && !error) |-> $past(fl_rd));
   // R8
   poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) polls_q <= PW'(MAX_POLLS));
   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_IDLE && $past(state) == S_IDLE) |-> (!fl_wr && !fl_rd));
endmodule

// File: tb/flash_cmd_driver_test.sv
`timescale 1ns/1ps
module flash_cmd_driver_test;
   localparam int AW = 19, MAXP = 20, RSTW = 625, INF = 10000;

   logic clk = 1'b0, rst_n = 1'b0;
   always #4 clk = ~clk;

   logic          req_valid = 1'b0;
   logic [1:0]    req_op = '0;
   logic [AW-1:0] req_addr = '0;
   logic [7:0]    req_data = '0;
   logic          busy, done, error, fl_wr, fl_rd;
   logic [AW-1:0] fl_addr;
   logic [7:0]    fl_dout, fl_din;

   flash_cmd_driver #(.ADDR_W(AW), .MAX_POLLS(MAXP), .RST_WAIT_CYC(RSTW)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_data(req_data), .busy(busy), .done(done),
      .error(error), .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_din(fl_din),
      .fl_wr(fl_wr), .fl_rd(fl_rd));

   int checks = 0, errors = 0;
   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // behavioural device: bit6 flips on each read until m_flips reads, bit5 from read m_e on
   int   m_flips = 0, m_e = 0, nr = 0;
   logic m_tog0 = 1'b0;
   always @(posedge clk) begin
      if (!rst_n || (req_valid && !busy)) nr <= 0;
      else if (fl_rd)                     nr <= nr + 1;
   end
   always_comb begin
      int k;
      k = (nr < m_flips) ? nr : m_flips;
      fl_din = 8'h00;
      fl_din[6] = m_tog0 ^ k[0];
      fl_din[5] = (m_e != 0) && (nr + 1 >= m_e);
   end

   logic [1:0]    tx_op = '0;
   logic [AW-1:0] tx_addr = '0;
   logic [7:0]    tx_data = '0;

   function automatic void exp_wr(input int idx, output logic [AW-1:0] a, output logic [7:0] d);
      int last;
      last = (tx_op == 2'd0) ? 3 : 5;
      a = AW'(16'h5555);
      d = 8'hAA;
      if (idx > last) d = 8'hF0;
      else case (idx)
         1, 4: begin a = AW'(16'h2AAA); d = 8'h55; end
         2: d = (tx_op == 2'd0) ? 8'hA0 : 8'h80;
         3: if (tx_op == 2'd0) begin a = tx_addr; d = tx_data; end
         5: if (tx_op == 2'd2) begin a = tx_addr; d = 8'h30; end else d = 8'h10;
         default: ;
      endcase
   endfunction

   // monitor at falling edges
   int cyc = 0, n_wr = 0, n_rd = 0, last_wr_cyc = 0, last_rd_cyc = 0, done_cyc = -1;
   bit done_err = 0, hold_pend = 0;
   logic [AW-1:0] prev_a = '0, h_a = '0;
   logic [7:0]    prev_d = '0, h_d = '0;
   always @(negedge clk) begin
      logic [AW-1:0] ea;
      logic [7:0] ed;
      string t;
      cyc++;
      if (rst_n) begin
         if (hold_pend) chk(fl_addr == h_a && fl_dout == h_d, "R5 hold", int'(fl_dout), int'(h_d));
         hold_pend = 0;
         if (fl_wr || fl_rd) chk(!(fl_wr && fl_rd), "R5 exclusive", 1, 0);
         if (fl_wr) begin
            chk(fl_addr == prev_a && fl_dout == prev_d, "R5 setup", int'(fl_addr), int'(prev_a));
            exp_wr(n_wr, ea, ed);
            t = (ed == 8'hF0 && n_wr > 3) ? "R9" : (tx_op == 2'd0) ? "R2" : (tx_op == 2'd1) ? "R3" : "R4";
            chk(fl_addr == ea && fl_dout == ed, t, int'({fl_addr, fl_dout}), int'({ea, ed}));
            h_a = fl_addr; h_d = fl_dout; hold_pend = 1;
            n_wr++; last_wr_cyc = cyc;
         end
         if (fl_rd) begin
            chk(fl_addr == tx_addr, "R6 read address", int'(fl_addr), int'(tx_addr));
            n_rd++; last_rd_cyc = cyc;
         end
         if (done) begin done_cyc = cyc; done_err = error; end
      end
      prev_a = fl_addr; prev_d = fl_dout;
   end

   function automatic void calc(input int flips, input int e, output bit err, output int reads, output bit tmo);
      int okr, fr, ee, n;
      bit f;
      okr = flips + 2;
      ee = (e < 2) ? 2 : e;
      fr = (e != 0 && ee <= flips) ? ee + 1 : 32'h3fffffff;
      f = fr < okr;
      n = f ? fr : okr;
      tmo = n > MAXP;
      err = tmo ? 1'b1 : f;
      reads = tmo ? MAXP : n;
   endfunction

   task automatic run_tx(input logic [1:0] op, input logic [AW-1:0] a, input logic [7:0] d,
                         input int flips, input int e, input bit garble);
      bit xe, tmo;
      int xr, nseq;
      string t;
      @(negedge clk);
      n_wr = 0; n_rd = 0; done_cyc = -1;
      m_flips = flips; m_e = e; m_tog0 = $urandom() & 1;
      tx_op = op; tx_addr = a; tx_data = d;
      req_op = op; req_addr = a; req_data = d; req_valid = 1'b1;
      @(negedge clk);
      req_valid = garble;
      for (int i = 0; i < 6; i++) begin
         if (garble) begin
            req_op = 2'($urandom() % 3); req_addr = AW'($urandom()); req_data = 8'($urandom());
         end
         @(negedge clk);
      end
      req_valid = 1'b0;
      while (!done) @(negedge clk);
      @(negedge clk);
      chk(!done && !busy, "R12 pulse", int'({done, busy}), 0);
      calc(flips, e, xe, xr, tmo);
      t = tmo ? "R8" : xe ? "R7" : "R6";
      if (garble) t = "R11";
      nseq = (op == 2'd0) ? 4 : 6;
      chk(done_err == xe, t, int'(done_err), int'(xe));
      chk(n_rd == xr, t, n_rd, xr);
      chk(n_wr == nseq + int'(xe), "R9 write count", n_wr, nseq + int'(xe));
      if (xe)
         chk(done_cyc - last_wr_cyc == ((op == 2'd0) ? 2 : RSTW + 2), "R10 recovery",
             done_cyc - last_wr_cyc, (op == 2'd0) ? 2 : RSTW + 2);
      else
         chk(done_cyc - last_rd_cyc == 1, "R6 done timing", done_cyc - last_rd_cyc, 1);
   endtask

   initial begin
      int s;
      s = $urandom(32'h5eed_0042);
      repeat (4) @(negedge clk);
      chk(!busy && !done && !error && !fl_wr && !fl_rd, "R1 in reset", int'({busy, done, error, fl_wr, fl_rd}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !error && !fl_wr && !fl_rd, "R1 after reset", int'({busy, done, error, fl_wr, fl_rd}), 0);

      // R11: opcode 3 is not taken
      n_wr = 0; n_rd = 0;
      req_op = 2'd3; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (5) @(negedge clk);
      chk(!busy && n_wr == 0 && n_rd == 0, "R11 opcode 3", n_wr + n_rd + int'(busy), 0);

      run_tx(2'd0, 19'h12345, 8'h5A, 3, 0, 0);      // R2 R6
      run_tx(2'd1, 19'h00000, 8'h00, 0, 0, 0);      // R3 R6 no toggle
      run_tx(2'd2, 19'h30000, 8'h00, 5, 0, 1);      // R4 R11 garbage while busy
      run_tx(2'd0, 19'h7FFFF, 8'hC3, 4, 5, 0);      // R7 recheck then success
      run_tx(2'd0, 19'h01234, 8'h11, 6, 3, 0);      // R7 R9 R10 failure
      run_tx(2'd1, 19'h00000, 8'h00, 8, 2, 0);      // R7 R10 erase recovery
      run_tx(2'd2, 19'h50000, 8'h00, INF, 0, 0);    // R8 timeout
      run_tx(2'd0, 19'h00001, 8'hFF, 25, 0, 0);     // R8 timeout
      run_tx(2'd0, 19'h40000, 8'h80, MAXP - 2, 0, 0); // R8 boundary: success on last read
      for (int i = 0; i < 20; i++) begin
         int f, e;
         f = ($urandom() % 6 == 0) ? INF : int'($urandom() % 14);
         e = ($urandom() % 2 == 0) ? 0 : int'(1 + $urandom() % 15);
         run_tx(2'($urandom() % 3), AW'($urandom()), 8'($urandom()), f, e, ($urandom() % 4) == 0);
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 190000);
      errors++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule